// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer peripheral with a small word-wide register interface. Software programs a 10-bit start value, releases the halt control, and then has to keep writing a reload command before the down-counter runs out. The counter steps once per tick. The tick comes from a parameterised divider of the input clock, nominally set for 0.6 s, and a bench can make it short.

Running out once is only a warning. The block latches a sticky timeout flag, can raise an interrupt, and starts counting again from the start value. If the counter runs out a second time while that flag is still set, the block records a second-timeout flag and a boot flag, and it raises a system reset request. A no-reboot control bit can block the reset request; the second-timeout flag is recorded either way.

The reset request stays high until the warm reset. The boot flag survives a warm reset and is cleared only by the cold reset or by software. Bus bridging and the unit that acts on the reset request are outside this block.

Top module: `twostage_watchdog`

## Requirements
- R1: After reset the registers read as follows:
  - control-1 (0x08) reads 0x0801: halt and no-reboot are both set.
  - status-1 (0x04), status-2 (0x06) and control-2 (0x0A) read 0.
  - the start-value register (0x12) and the count (0x00) read 4.
  - `irq` and `resetReq` are low.
- R2: The start value is held in bits 9:0 of register 0x12. Bits 15:10 of that register always read 0, whatever is written to them. A write whose bits 9:0 are 0 to 3 is ignored, and the previous start value stays.
- R3: A write of exactly 0x0001 to register 0x00 loads the counter from the start value at the next clock edge. A write of any other value to 0x00 has no effect. Reading 0x00 returns the live count in bits 9:0.
- R4: Bit 11 of register 0x08 is the halt bit and reads back as written. While it is 1 the count does not change. While it is 0 the count drops by one on each tick, and a tick occurs once every TICK_DIV clocks.
- R5: On a tick that finds the count at 0 (with halt clear), the counter expires and reloads from the start value. A reload write in the same cycle takes priority over the tick.
- R6: An expiry while status bit 3 of register 0x04 is clear sets that bit. Writing a 1 to bit 3 clears it. If an expiry and a clear fall in the same cycle, the set wins.
- R7: An expiry while register 0x04 bit 3 is already set does the following:
  - it sets register 0x06 bit 1, which is cleared by writing a 1 to it;
  - if register 0x08 bit 0 (no-reboot) is 0, it raises `resetReq`, which stays high until the warm reset.
- R8: Register 0x06 bit 2 (boot flag) is set together with `resetReq`. It survives a warm reset (`rstN`). It is cleared by the cold reset (`porN`) or by writing a 1 to it.
- R9: `irq` is high exactly while control-2 bit 0 (interrupt enable, at register 0x0A) and register 0x04 bit 3 are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous warm reset, active low |
| porN | input | 1 | Asynchronous cold reset for the boot flag, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | 5 | Register byte offset |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `addr`, combinational |
| irq | output | 1 | Timeout interrupt |
| resetReq | output | 1 | System reset request |

## Verification
The assertions take three things about the inputs for granted:
- `porN` is only ever asserted while `rstN` is also low.
- TICK_DIV is at least 2.
- The write strobe is sampled only on clock edges.

The bench keeps within these limits. It always pulses both resets together for a cold start, it uses a four-clock tick, and it drives every input on the falling edge. The random stimulus keeps start values small and clears the halt bit most of the time, so that single and double expiries happen often. It also issues a warm reset after every reset request, so that the boot flag's survival across that reset is checked again and again.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W  = 10;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;
  localparam logic [CNT_W-1:0] INIT_RESET = CNT_W'(4);
  localparam logic [CNT_W-1:0] INIT_MIN   = CNT_W'(4);

  localparam logic [ADDR_W-1:0] OFF_RELOAD = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_STS1   = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_STS2   = 5'h06;
  localparam logic [ADDR_W-1:0] OFF_CTL1   = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_CTL2   = 5'h0A;
  localparam logic [ADDR_W-1:0] OFF_INIT   = 5'h12;

  localparam int BIT_HALT   = 11;
  localparam int BIT_NORB   = 0;
  localparam int BIT_TO     = 3;
  localparam int BIT_SECOND = 1;
  localparam int BIT_BOOT   = 2;
  localparam int BIT_INTEN  = 0;

  typedef struct packed {
    logic             reload;
    logic             halt;
    logic [CNT_W-1:0] initVal;
  } ctlStb_t;
endpackage

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_pkg::*;
#(
  parameter int TICK_DIV = 30_000_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStb_t          stb,
  output logic             expire,
  output logic [CNT_W-1:0] count
);
  localparam int DIV_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] tickCnt;
  logic             tick;
  logic             step;

  assign tick   = (tickCnt == DIV_LAST);
  assign step   = tick && !stb.halt;
  assign expire = step && (count == '0) && !stb.reload;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tickCnt <= '0;
    else if (tick) tickCnt <= '0;
    else tickCnt <= tickCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= INIT_RESET;
    else if (stb.reload) count <= stb.initVal;
    else if (step) begin
      if (count == '0) count <= stb.initVal;
      else count <= count - 1'b1;
    end
  end

  // R3 / R5: a reload strobe loads the start value, ahead of any tick
  a_r5_reload_wins: assert property (@(posedge clk) disable iff (!rstN)
    stb.reload |=> count == $past(stb.initVal));

  // R4: a halted counter holds its value
  a_r4_halt_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (stb.halt && !stb.reload) |=> $stable(count));

  // R5: an expiry restarts the count from the start value
  a_r5_expire_reload: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> count == $past(stb.initVal));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              porN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              expire,
  input  logic [CNT_W-1:0]  count,
  output ctlStb_t           stb,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              resetReq
);
  logic             halt, noReboot, intEn;
  logic             timeoutSts, secondSts, bootSts;
  logic [CNT_W-1:0] initVal;
  logic             wrCtl1, wrCtl2, wrInit, wrSts1, wrSts2;
  logic             firstHit, secondHit, fireReset;

  assign wrCtl1 = wrEn && (addr == OFF_CTL1);
  assign wrCtl2 = wrEn && (addr == OFF_CTL2);
  assign wrInit = wrEn && (addr == OFF_INIT) && (wrData[CNT_W-1:0] >= INIT_MIN);
  assign wrSts1 = wrEn && (addr == OFF_STS1);
  assign wrSts2 = wrEn && (addr == OFF_STS2);

  assign firstHit  = expire && !timeoutSts;
  assign secondHit = expire && timeoutSts;
  assign fireReset = secondHit && !noReboot;

  assign stb.reload  = wrEn && (addr == OFF_RELOAD) && (wrData == DATA_W'(1));
  assign stb.halt    = halt;
  assign stb.initVal = initVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halt     <= 1'b1;
      noReboot <= 1'b1;
      intEn    <= 1'b0;
      initVal  <= INIT_RESET;
    end else begin
      if (wrCtl1) begin
        halt     <= wrData[BIT_HALT];
        noReboot <= wrData[BIT_NORB];
      end
      if (wrCtl2) intEn <= wrData[BIT_INTEN];
      if (wrInit) initVal <= wrData[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeoutSts <= 1'b0;
      secondSts  <= 1'b0;
      resetReq   <= 1'b0;
    end else begin
      if (firstHit) timeoutSts <= 1'b1;
      else if (wrSts1 && wrData[BIT_TO]) timeoutSts <= 1'b0;
      if (secondHit) secondSts <= 1'b1;
      else if (wrSts2 && wrData[BIT_SECOND]) secondSts <= 1'b0;
      if (fireReset) resetReq <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) bootSts <= 1'b0;
    else if (fireReset) bootSts <= 1'b1;
    else if (wrSts2 && wrData[BIT_BOOT]) bootSts <= 1'b0;
  end

  assign irq = intEn && timeoutSts;

  always_comb begin
    rdData = '0;
    unique case (addr)
      OFF_RELOAD: rdData[CNT_W-1:0] = count;
      OFF_STS1:   rdData[BIT_TO] = timeoutSts;
      OFF_STS2:   begin
        rdData[BIT_SECOND] = secondSts;
        rdData[BIT_BOOT]   = bootSts;
      end
      OFF_CTL1:   begin
        rdData[BIT_HALT] = halt;
        rdData[BIT_NORB] = noReboot;
      end
      OFF_CTL2:   rdData[BIT_INTEN] = intEn;
      OFF_INIT:   rdData[CNT_W-1:0] = initVal;
      default:    rdData = '0;
    endcase
  end

  // R2: the stored start value is never below the legal minimum
  a_r2_init_legal: assert property (@(posedge clk) disable iff (!rstN)
    initVal >= INIT_MIN);

  // R6: an expiry leaves the timeout flag set
  a_r6_first_sets: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> timeoutSts);

  // R7: a second expiry with reboot allowed requests reset
  a_r7_second_reset: assert property (@(posedge clk) disable iff (!rstN)
    (expire && timeoutSts && !noReboot) |=> (resetReq && secondSts));

  // R7: the reset request holds until warm reset
  a_r7_req_sticky: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> resetReq);

  // R8: the boot flag rises only together with a reset request
  a_r8_boot_with_req: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bootSts) |-> $rose(resetReq));
endmodule

// File: rtl/twostage_watchdog.sv
module twostage_watchdog
  import wdt_pkg::*;
#(
  parameter int TICK_DIV = 30_000_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        porN,
  input  logic        wrEn,
  input  logic [4:0]  addr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        irq,
  output logic        resetReq
);
  ctlStb_t          stb;
  logic             expire;
  logic [CNT_W-1:0] count;

  wdt_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .porN(porN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .expire(expire), .count(count), .stb(stb),
    .rdData(rdData), .irq(irq), .resetReq(resetReq)
  );

  wdt_count #(.TICK_DIV(TICK_DIV)) i_count (
    .clk(clk), .rstN(rstN), .stb(stb), .expire(expire), .count(count)
  );
endmodule

// File: tb/test_twostage_watchdog.sv
module test_twostage_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0, porN = 1'b0, wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        irq, resetReq;

  int errors = 0, checks = 0;

  twostage_watchdog #(.TICK_DIV(TDIV)) i_twostage_watchdog (
    .clk(clk), .rstN(rstN), .porN(porN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq), .resetReq(resetReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model of the register-level behaviour
  int       mTick;
  bit [9:0] mCnt, mInit;
  bit       mHalt, mNoRb, mIntEn, mTo, mSec, mBoot, mReq;

  always @(posedge clk) begin
    bit tk, rl, ex;
    if (!rstN) begin
      mTick = 0; mCnt = 10'd4; mInit = 10'd4; mHalt = 1; mNoRb = 1;
      mIntEn = 0; mTo = 0; mSec = 0; mReq = 0;
    end else begin
      tk = (mTick == TDIV-1);
      mTick = tk ? 0 : mTick + 1;
      rl = wrEn && addr == 5'h00 && wrData == 16'h0001;
      ex = tk && !mHalt && mCnt == 0 && !rl;
      if (rl) mCnt = mInit;
      else if (tk && !mHalt) mCnt = (mCnt == 0) ? mInit : mCnt - 10'd1;
      if (ex && mTo) begin
        mSec = 1;
        if (!mNoRb) begin mReq = 1; mBoot = 1; end
      end else if (wrEn && addr == 5'h06) begin
        if (wrData[1]) mSec = 0;
        if (wrData[2]) mBoot = 0;
      end else if (wrEn && addr == 5'h06 && wrData[2]) mBoot = 0;
      if (ex && !mTo) mTo = 1;
      else if (wrEn && addr == 5'h04 && wrData[3]) mTo = 0;
      if (wrEn && addr == 5'h08) begin mHalt = wrData[11]; mNoRb = wrData[0]; end
      if (wrEn && addr == 5'h0A) mIntEn = wrData[0];
      if (wrEn && addr == 5'h12 && wrData[9:0] >= 10'd4) mInit = wrData[9:0];
    end
    if (!porN) mBoot = 0;
  end

  function automatic logic [15:0] expReg(logic [4:0] a);
    case (a)
      5'h00: return {6'b0, mCnt};
      5'h04: return {12'b0, mTo, 3'b0};
      5'h06: return {13'b0, mBoot, mSec, 1'b0};
      5'h08: return {4'b0, mHalt, 10'b0, mNoRb};
      5'h0A: return {15'b0, mIntEn};
      5'h12: return {6'b0, mInit};
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rdChk(string tag, logic [4:0] a);
    @(negedge clk); addr = a; #1;
    chk(tag, rdData, expReg(a));
    chk({tag, " irq R9"}, {15'b0, irq}, {15'b0, mIntEn & mTo});
    chk({tag, " resetReq R7"}, {15'b0, resetReq}, {15'b0, mReq});
  endtask

  task automatic warmReset();
    @(negedge clk); rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  task automatic coldReset();
    @(negedge clk); rstN = 0; porN = 0;
    repeat (2) @(negedge clk);
    porN = 1; rstN = 1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    coldReset();

    // R1: literal reset values
    @(negedge clk); addr = 5'h08; #1; chk("R1 ctl1", rdData, 16'h0801);
    addr = 5'h12; #1; chk("R1 init", rdData, 16'h0004);
    addr = 5'h00; #1; chk("R1 count", rdData, 16'h0004);
    addr = 5'h06; #1; chk("R1 sts2", rdData, 16'h0000);
    chk("R1 outputs", {14'b0, irq, resetReq}, 16'h0);

    // R2: upper bits read zero, illegal start values ignored
    wr(5'h12, 16'hFC08); rdChk("R2 upper bits", 5'h12);
    @(negedge clk); #1; chk("R2 literal", rdData, 16'h0008);
    wr(5'h12, 16'h0003); rdChk("R2 illegal ignored", 5'h12);
    @(negedge clk); #1; chk("R2 keep 8", rdData, 16'h0008);

    // R4: halted counter frozen across many ticks
    repeat (20) @(negedge clk);
    rdChk("R4 halted", 5'h00);

    // R3: reload with wrong value ignored, with 1 loads
    wr(5'h08, 16'h0000);
    repeat (9) @(negedge clk);
    wr(5'h00, 16'h0002); rdChk("R3 bad reload ignored", 5'h00);
    wr(5'h00, 16'h0001); rdChk("R3 reload", 5'h00);
    rdChk("R4 ctl1 readback", 5'h08);

    // R6/R9: first expiry with interrupt enabled
    wr(5'h0A, 16'h0001);
    repeat (45) @(negedge clk);
    rdChk("R6 first expiry", 5'h04);
    wr(5'h04, 16'h0008); rdChk("R6 w1c", 5'h04);

    // R7/R8: second expiry with reboot allowed
    repeat (90) @(negedge clk);
    rdChk("R7 second sts", 5'h06);
    warmReset();
    rdChk("R8 boot survives warm", 5'h06);
    wr(5'h06, 16'h0004); rdChk("R8 boot w1c", 5'h06);

    // R7: no-reboot inhibits the request
    wr(5'h12, 16'h0004); wr(5'h08, 16'h0001);
    repeat (60) @(negedge clk);
    rdChk("R7 inhibited", 5'h06);

    // R5: reload just as the counter would expire, plus random mix
    for (int i = 0; i < 400; i++) begin
      int op = $urandom % 8;
      logic [4:0] offs [6] = '{5'h00, 5'h04, 5'h06, 5'h08, 5'h0A, 5'h12};
      case (op)
        0: wr(5'h00, 16'($urandom % 3));
        1: wr(5'h12, {6'($urandom), 10'($urandom % 12)});
        2: wr(5'h08, {4'b0, ($urandom % 5 == 0), 10'b0, 1'($urandom)});
        3: wr(5'h04, ($urandom % 2) ? 16'h0008 : 16'h0000);
        4: wr(5'h06, {13'b0, 2'($urandom), 1'b0});
        5: wr(5'h0A, 16'($urandom % 2));
        default: repeat ($urandom % 30) @(negedge clk);
      endcase
      rdChk("R5 random", offs[$urandom % 6]);
      if (mReq) begin
        warmReset();
        rdChk("R8 random warm", 5'h06);
      end
    end

    coldReset();
    rdChk("R8 cold clears boot", 5'h06);
    summary();
  end
endmodule